// File: doc/BRIEF.md
# DDR Power-State Manager

This block owns the clock-enable pin of a DDR memory and decides when the memory may drop into a powerdown state to save energy. It watches the request line from the command scheduler and a flag from the bank tracker that says whether a row is currently open, meaning the sense amplifiers still hold data. Those two facts, CKE level and row status, select one of four power states. Standby with an open row draws the most power. Standby with all banks precharged draws a little less. Powerdown with an open row is lower again, and powerdown with all banks precharged is the lowest.

Dropping CKE only pays off when the memory stays idle longer than a break-even time, so the block counts consecutive idle cycles and lowers CKE only after a programmable threshold. When a request arrives during powerdown, CKE goes high at once. The ready flag stays low for a programmable resynchronisation count, so the scheduler issues nothing until the memory can accept it. The reported state code follows the row status captured at the last powered-up cycle, because no command can change it while CKE is low or resynchronising.

Top module: `ddr_pwr_mgr`

## Requirements
- R1: After reset, cke_o is 1, ready_o is 1 and pstate_o is 2'b10 (no row recorded, CKE high).
- R2: While ready_o is 1, the clock edge that samples the idle_th_i-th consecutive cycle with req_i low drives cke_o to 0 and ready_o to 0. Any cycle with req_i high restarts the count.
- R3: pstate_o is {~row, ~cke_o}, where row is the recorded row status: 2'b00 active standby, 2'b01 active powerdown, 2'b10 precharge standby, 2'b11 precharge powerdown.
- R4: The recorded row status follows row_open_i on every edge while ready_o is 1. It is frozen while cke_o is 0 and during resynchronisation, so changes on row_open_i then do not alter pstate_o.
- R5: While cke_o is 0 and req_i is sampled low, cke_o and ready_o both stay 0.
- R6: The edge that samples req_i high while cke_o is 0 drives cke_o to 1.
- R7: ready_o rises exactly resync_cyc_i clock edges after the edge that raised cke_o. If resync_cyc_i is 0, ready_o rises on that same edge.
- R8: ready_o is never 1 while cke_o is 0. While ready_o is 1 and req_i is high, cke_o stays 1. A request held during resynchronisation does not shorten it.
- R9: If req_i is high in the cycle where the idle count would reach the threshold, the request wins: cke_o stays 1 and a full new idle run of idle_th_i cycles is needed.
- R10: With idle_th_i equal to 0, powerdown is never entered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Scheduler has a request pending |
| row_open_i | input | 1 | At least one bank has an open row |
| idle_th_i | input | CNT_W | Idle cycles before powerdown entry; 0 disables entry |
| resync_cyc_i | input | CNT_W | Cycles from CKE rise to ready |
| cke_o | output | 1 | Clock enable to the memory |
| pstate_o | output | 2 | Current power-state code |
| ready_o | output | 1 | Scheduler may issue commands |

## Verification
The two functions that can fall in the same cycle are expiry of the idle threshold and arrival of a new request. The request must win, and the idle count must restart. A directed sequence lets the count run to one short of the threshold and then raises the request in exactly the deciding cycle. Random traffic with small thresholds and a 25% request rate then provokes the same collision many more times. In every cycle, CKE, ready and the state code are compared against a cycle-level model built from the requirements.

// File: rtl/ddr_pm_pkg.sv
package ddr_pm_pkg;

    typedef enum logic [1:0] {
        PH_UP   = 2'd0,
        PH_DOWN = 2'd1,
        PH_WAKE = 2'd2
    } pm_phase_e;

    typedef enum logic [1:0] {
        PS_ACT_STBY = 2'b00,
        PS_ACT_PD   = 2'b01,
        PS_PRE_STBY = 2'b10,
        PS_PRE_PD   = 2'b11
    } pwr_state_e;

    typedef struct packed {
        pm_phase_e phase;
        logic      cke;
        logic      ready;
        logic      row;
    } pm_ctl_t;

    localparam pm_ctl_t PM_CTL_RESET = '{phase: PH_UP, cke: 1'b1, ready: 1'b1, row: 1'b0};

    function automatic pwr_state_e encode_state(input logic row, input logic cke);
        pwr_state_e s;
        case ({row, cke})
            2'b11:   s = PS_ACT_STBY;
            2'b10:   s = PS_ACT_PD;
            2'b01:   s = PS_PRE_STBY;
            default: s = PS_PRE_PD;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/ddr_pm_idle_timer.sv
module ddr_pm_idle_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             clr_i,
    input  logic [CNT_W-1:0] th_i,
    output logic             hit_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W:0]   run_len;

    always_comb begin
        run_len = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};
        hit_o   = run_i && !clr_i && (th_i != '0) && (run_len >= {1'b0, th_i});
        cnt_d   = cnt_q;
        if (clr_i || hit_o) begin
            cnt_d = '0;
        end else if (run_i && cnt_q != CNT_MAX) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R10: a zero threshold keeps the block powered up whatever the count
    a_r10_zero_th_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (th_i == '0) |-> !hit_o);

endmodule

// File: rtl/ddr_pm_resync_timer.sv
module ddr_pm_resync_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] val_i,
    input  logic             tick_i,
    output logic             last_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)                     cnt_d = val_i;
        else if (tick_i && cnt_q != '0) cnt_d = cnt_q - 1'b1;
        last_o = (cnt_q == {{(CNT_W-1){1'b0}}, 1'b1});
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/ddr_pwr_mgr.sv
module ddr_pwr_mgr
    import ddr_pm_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    input  logic             row_open_i,
    input  logic [CNT_W-1:0] idle_th_i,
    input  logic [CNT_W-1:0] resync_cyc_i,
    output logic             cke_o,
    output logic [1:0]       pstate_o,
    output logic             ready_o
);
    pm_ctl_t ctl_d, ctl_q;
    logic    idle_run, idle_clr, idle_hit;
    logic    rs_load, rs_tick, rs_last;

    assign idle_run = (ctl_q.phase == PH_UP) && !req_i;
    assign idle_clr = (ctl_q.phase != PH_UP) || req_i;
    assign rs_tick  = (ctl_q.phase == PH_WAKE);

    ddr_pm_idle_timer #(.CNT_W(CNT_W)) u_idle (
        .clk   (clk),
        .rst_n (rst_n),
        .run_i (idle_run),
        .clr_i (idle_clr),
        .th_i  (idle_th_i),
        .hit_o (idle_hit)
    );

    ddr_pm_resync_timer #(.CNT_W(CNT_W)) u_resync (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (rs_load),
        .val_i  (resync_cyc_i),
        .tick_i (rs_tick),
        .last_o (rs_last)
    );

    always_comb begin
        ctl_d   = ctl_q;
        rs_load = 1'b0;
        case (ctl_q.phase)
            PH_UP: begin
                ctl_d.row = row_open_i;
                if (idle_hit) begin
                    ctl_d.phase = PH_DOWN;
                    ctl_d.cke   = 1'b0;
                    ctl_d.ready = 1'b0;
                end
            end
            PH_DOWN: begin
                if (req_i) begin
                    ctl_d.cke = 1'b1;
                    if (resync_cyc_i == '0) begin
                        ctl_d.phase = PH_UP;
                        ctl_d.ready = 1'b1;
                    end else begin
                        ctl_d.phase = PH_WAKE;
                        rs_load     = 1'b1;
                    end
                end
            end
            PH_WAKE: begin
                if (rs_last) begin
                    ctl_d.phase = PH_UP;
                    ctl_d.ready = 1'b1;
                end
            end
            default: ctl_d = PM_CTL_RESET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= PM_CTL_RESET;
        else        ctl_q <= ctl_d;
    end

    assign cke_o    = ctl_q.cke;
    assign ready_o  = ctl_q.ready;
    assign pstate_o = encode_state(ctl_q.row, ctl_q.cke);

    // R8: commands may only be released with CKE high
    a_r8_ready_needs_cke: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |-> cke_o);

    // R8, R9: a pending request while serving keeps the memory powered
    a_r9_req_keeps_up: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && req_i) |=> cke_o);

    // R2: CKE only falls after an idle sample
    a_r2_fall_after_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cke_o) |-> $past(!req_i));

    // R4, R5: no request while down keeps CKE low and the state code frozen
    a_r5_stay_down: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_o && !req_i) |=> (!cke_o && !ready_o && $stable(pstate_o)));

    // R6: wake raises CKE and holds ready low when a resync count is set
    a_r6_wake_holds_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_o && req_i && resync_cyc_i != '0) |=> (cke_o && !ready_o));

    // R7: a zero resync count releases ready together with CKE
    a_r7_zero_resync: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_o && req_i && resync_cyc_i == '0) |=> (cke_o && ready_o));

endmodule

// File: tb/ddr_pwr_mgr_bench.sv
module ddr_pwr_mgr_bench;
    localparam int CNT_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req = 1'b0;
    logic             row_open = 1'b0;
    logic [CNT_W-1:0] idle_th = 8'd4;
    logic [CNT_W-1:0] resync = 8'd3;
    logic             cke;
    logic [1:0]       pstate;
    logic             ready;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // reference model state
    int m_cke, m_ready, m_row, m_idle, m_wait;

    always #5 clk = ~clk;

    ddr_pwr_mgr #(.CNT_W(CNT_W)) u_ddr_pwr_mgr (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_i        (req),
        .row_open_i   (row_open),
        .idle_th_i    (idle_th),
        .resync_cyc_i (resync),
        .cke_o        (cke),
        .pstate_o     (pstate),
        .ready_o      (ready)
    );

    function automatic logic [1:0] exp_code(input int row, input int ck);
        return {row == 0, ck == 0};
    endfunction

    task automatic check(input string tag, input int got, input int exp);
        n_run++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, got, exp);
        end
    endtask

    task automatic model_update();
        if (!rst_n) begin
            m_cke = 1; m_ready = 1; m_row = 0; m_idle = 0; m_wait = 0;
        end else if (m_ready == 1) begin
            m_row = row_open;
            if (req) begin
                m_idle = 0;
            end else if (idle_th != 0 && m_idle + 1 >= int'(idle_th)) begin
                m_cke = 0; m_ready = 0; m_idle = 0;
            end else begin
                m_idle = m_idle + 1;
            end
        end else if (m_cke == 0) begin
            if (req) begin
                m_cke = 1;
                m_wait = int'(resync);
                m_ready = (resync == 0) ? 1 : 0;
            end
        end else begin
            m_wait = m_wait - 1;
            if (m_wait == 0) m_ready = 1;
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
        model_update();
        check("R2/R6 model cke", cke, m_cke);
        check("R7/R8 model ready", ready, m_ready);
        check("R3/R4 model pstate", pstate, exp_code(m_row, m_cke));
    endtask

    task automatic steps(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    initial begin : watchdog
        #2_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin : stim
        void'($urandom(32'd20240611));
        steps(2);
        check("R1 reset cke", cke, 1);
        check("R1 reset ready", ready, 1);
        check("R1 reset pstate", pstate, 2'b10);

        // R2, R3: idle run into active powerdown
        rst_n = 1'b1; row_open = 1'b1; req = 1'b0; idle_th = 8'd4; resync = 8'd3;
        steps(3);
        check("R2 before threshold cke", cke, 1);
        step();
        check("R2 entry cke", cke, 0);
        check("R2 entry ready", ready, 0);
        check("R3 active powerdown code", pstate, 2'b01);

        // R4, R5: row input moves while down
        row_open = 1'b0;
        steps(5);
        check("R4 frozen code", pstate, 2'b01);
        check("R5 stays down cke", cke, 0);

        // R6, R7, R8: wake with resync of 3
        req = 1'b1; row_open = 1'b1;
        step();
        check("R6 wake cke", cke, 1);
        check("R6 wake ready", ready, 0);
        check("R3 active standby code", pstate, 2'b00);
        steps(2);
        check("R8 held req no shortcut", ready, 0);
        step();
        check("R7 ready after resync", ready, 1);
        steps(10);
        check("R8 req keeps cke", cke, 1);

        // R9: request in the deciding cycle
        req = 1'b0;
        steps(3);
        req = 1'b1;
        step();
        check("R9 req wins cke", cke, 1);
        req = 1'b0;
        steps(3);
        check("R9 count restarted cke", cke, 1);
        step();
        check("R9 later entry cke", cke, 0);

        // R7 zero resync, R3 precharge powerdown
        req = 1'b1; resync = 8'd0; row_open = 1'b0;
        step();
        check("R7 zero resync ready", ready, 1);
        check("R4 code held at wake", pstate, 2'b00);
        req = 1'b0; idle_th = 8'd2;
        step();
        check("R3 precharge standby code", pstate, 2'b10);
        step();
        check("R3 precharge powerdown code", pstate, 2'b11);

        // R10: zero threshold
        req = 1'b1;
        step();
        req = 1'b0; idle_th = 8'd0;
        steps(20);
        check("R10 no entry cke", cke, 1);

        // random traffic, R9 collisions with small thresholds
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 63) == 0) idle_th = 8'($urandom_range(0, 6));
            if ($urandom_range(0, 63) == 0) resync = 8'($urandom_range(0, 5));
            req = ($urandom_range(0, 3) == 0);
            if ($urandom_range(0, 7) == 0) row_open = ~row_open;
            step();
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule